// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the register file of a device that lets several compute nodes share a memory region. It gives software on the local node four 32-bit registers: an interrupt mask, an interrupt status flag, a read-only identifier for this node and a doorbell. Writing the doorbell sends a request to another node. The request carries the target node number in the upper half of the written word and a vector number in the lower half.

Doorbells that arrive from other nodes are handled in one of two interrupt schemes. The scheme is fixed at reset.

- **Pin scheme:** an arrival sets a one-bit status flag. The flag is gated by the mask to form a level interrupt, and reading the status clears it.
- **Message scheme:** the status and the mask play no part. An arrival with a valid vector number pulses one line of a per-vector output for a single cycle. An arrival whose vector number is out of range is dropped, and a sticky error flag is raised.

The identifier register reads as all ones until the node reports that it is ready.

Top module: `nodebell_regs`

## Requirements
- R1: Registers are selected by byte offset: 0 is the mask, 4 the status, 8 the node identifier, 12 the doorbell. The mask keeps and returns all 32 written bits.
- R2: In pin scheme, an incoming event sets the status register to 1 at the next clock edge. The register reads as 0 after reset.
- R3: `irq_level` is high only in pin scheme, when mask bit 0 and the status are both 1. The other mask bits have no effect on it.
- R4: Offset 8 reads all ones while `node_ready` is low. While `node_ready` is high it reads `node_id`, zero-extended to 32 bits.
- R5: A write to offset 12 makes `bell_req_valid` high for exactly the next cycle. In that cycle `bell_req_dest` carries written bits [31:16] and `bell_req_vec` carries written bits [15:0].
- R6: In pin scheme, the vector number of an incoming event is ignored: any value sets the status.
- R7: In message scheme, an incoming event with vector v below `VEC_COUNT` drives `vec_pulse` to a one-hot word with bit v set, for one cycle. The status stays 0 and `irq_level` stays low.
- R8: In message scheme, an incoming event with vector v of `VEC_COUNT` or more produces no pulse. It sets `vec_err`, which stays high until reset.
- R9: Reading offset 4 returns the status and clears it. If an event arrives in the same cycle as that read, the status stays 1.
- R10: Writes to offset 8 have no effect. Reads of offset 12 return 0. Reads of unmapped or unaligned offsets (any address with bits [1:0] non-zero or bits above 3 set) return 0.
- R11: The interrupt scheme is taken from `cfg_msg_mode` (1 = message, 0 = pin) only while `rst` is high. Later changes of that input have no effect.
- R12: `reg_rdata` presents the value read one cycle after `reg_rd_en`. It is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msg_mode | input | 1 | Interrupt scheme select, sampled during reset |
| node_ready | input | 1 | Node identifier is valid |
| node_id | input | NODE_W | Identifier of this node |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| bell_req_valid | output | 1 | Outgoing doorbell request strobe |
| bell_req_dest | output | 16 | Target node of the request |
| bell_req_vec | output | 16 | Vector of the request |
| evt_valid | input | 1 | Incoming doorbell event strobe |
| evt_vec | input | 16 | Vector of the incoming event |
| irq_level | output | 1 | Level interrupt, pin scheme |
| vec_pulse | output | VEC_COUNT | Per-vector one-cycle pulse, message scheme |
| vec_err | output | 1 | Sticky out-of-range vector flag |

## Verification
The assertions assume three things about the inputs:
- `cfg_msg_mode` is only meaningful while `rst` is high.
- `evt_valid` and the register strobes are single-cycle requests, sampled at the rising edge.
- `node_id` fits the identifier field.

The stimulus changes inputs only on the falling clock edge. It switches the interrupt scheme only through a reset, except in one deliberate case. That case flips `cfg_msg_mode` outside reset to show the change is ignored. Register reads and event arrivals are issued together in one cycle only where the read-to-clear race is the point of the check.

// File: rtl/nodebell_pkg.sv
`timescale 1ns/1ps
package nodebell_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned FIELD_W = 16;

    // Register slot selected by byte-offset bits [3:2]
    typedef enum logic [1:0] {
        SLOT_MASK   = 2'd0,
        SLOT_STATUS = 2'd1,
        SLOT_POSN   = 2'd2,
        SLOT_BELL   = 2'd3
    } slot_e;

    typedef enum logic {
        MODE_PIN = 1'b0,
        MODE_MSG = 1'b1
    } irq_mode_e;

    // Doorbell word: target node in the upper half, vector in the lower half
    typedef struct packed {
        logic [FIELD_W-1:0] dest;
        logic [FIELD_W-1:0] vec;
    } bell_word_t;

    typedef struct packed {
        logic  hit;
        slot_e slot;
    } decode_t;

    function automatic logic vec_in_range(input logic [FIELD_W-1:0] v,
                                          input int unsigned count);
        return (32'(v) < count);
    endfunction
endpackage

// File: rtl/nodebell_decode.sv
`timescale 1ns/1ps
module nodebell_decode
    import nodebell_pkg::*;
#(
    parameter int unsigned ADDR_W = 6   // must be at least 5
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    // Mapped only when word-aligned and inside the 16-byte window
    always_comb begin
        dec.hit  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:4] == '0);
        dec.slot = slot_e'(addr[3:2]);
    end
endmodule

// File: rtl/nodebell_outreq.sv
`timescale 1ns/1ps
module nodebell_outreq
    import nodebell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bell_wr,
    input  logic [REG_W-1:0] wdata,
    output logic             req_valid,
    output bell_word_t       req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req       <= '0;
        end else begin
            req_valid <= bell_wr;
            if (bell_wr) req <= bell_word_t'(wdata);
        end
    end

    AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bell_wr |=> !req_valid);                                       // R5
    AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (rst)
        bell_wr |=> (req_valid && req == bell_word_t'($past(wdata))));  // R5
endmodule

// File: rtl/nodebell_irq.sv
`timescale 1ns/1ps
module nodebell_irq
    import nodebell_pkg::*;
#(
    parameter int unsigned VEC_COUNT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_msg_mode,
    input  logic                 evt_valid,
    input  logic [FIELD_W-1:0]   evt_vec,
    input  logic                 mask_bit0,
    input  logic                 status_rd,
    output logic                 status,
    output logic                 irq_level,
    output logic [VEC_COUNT-1:0] vec_pulse,
    output logic                 vec_err
);
    irq_mode_e            mode_q;
    logic                 status_q;
    logic [VEC_COUNT-1:0] pulse_q;
    logic                 err_q;
    logic [VEC_COUNT-1:0] vec_hot;
    logic                 vec_ok;

    for (genvar g = 0; g < VEC_COUNT; g++) begin : g_vec
        assign vec_hot[g] = (evt_vec == FIELD_W'(g));
    end

    assign vec_ok = vec_in_range(evt_vec, VEC_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= irq_mode_e'(cfg_msg_mode);
            status_q <= 1'b0;
            pulse_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            pulse_q <= '0;
            if (mode_q == MODE_PIN) begin
                // Arrival wins over the read-to-clear
                if (evt_valid)      status_q <= 1'b1;
                else if (status_rd) status_q <= 1'b0;
            end else if (evt_valid) begin
                if (vec_ok) pulse_q <= vec_hot;
                else        err_q   <= 1'b1;
            end
        end
    end

    assign status    = status_q;
    assign irq_level = (mode_q == MODE_PIN) && mask_bit0 && status_q;
    assign vec_pulse = pulse_q;
    assign vec_err   = err_q;

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));                                      // R11
    AST_PIN_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PIN && evt_valid) |=> status_q);               // R2
    AST_MSG_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_MSG) |-> !status_q);                           // R7
    AST_IRQ_PIN_ONLY: assert property (@(posedge clk) disable iff (rst)
        irq_level |-> (mode_q == MODE_PIN));                           // R7
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q));                                            // R7
    AST_NO_EVT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |=> (pulse_q == '0));                               // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);                                              // R8
endmodule

// File: rtl/nodebell_regs.sv
`timescale 1ns/1ps
module nodebell_regs
    import nodebell_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned NODE_W    = 16,
    parameter int unsigned VEC_COUNT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_msg_mode,
    input  logic                 node_ready,
    input  logic [NODE_W-1:0]    node_id,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 bell_req_valid,
    output logic [15:0]          bell_req_dest,
    output logic [15:0]          bell_req_vec,
    input  logic                 evt_valid,
    input  logic [15:0]          evt_vec,
    output logic                 irq_level,
    output logic [VEC_COUNT-1:0] vec_pulse,
    output logic                 vec_err
);
    decode_t          dec;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] rd_mux;
    logic             status;
    logic             status_rd;
    logic             bell_wr;
    bell_word_t       req;

    nodebell_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .dec  (dec)
    );

    assign status_rd = reg_rd_en && dec.hit && (dec.slot == SLOT_STATUS);
    assign bell_wr   = reg_wr_en && dec.hit && (dec.slot == SLOT_BELL);

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else if (reg_wr_en && dec.hit && dec.slot == SLOT_MASK) mask_q <= reg_wdata;
    end

    always_comb begin
        rd_mux = '0;
        if (dec.hit) begin
            unique case (dec.slot)
                SLOT_MASK:   rd_mux = mask_q;
                SLOT_STATUS: rd_mux = REG_W'(status);
                SLOT_POSN:   rd_mux = node_ready ? REG_W'(node_id) : '1;
                SLOT_BELL:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata_q <= '0;
        else if (reg_rd_en) rdata_q <= rd_mux;
        else                rdata_q <= '0;
    end
    assign reg_rdata = rdata_q;

    nodebell_irq #(.VEC_COUNT(VEC_COUNT)) u_irq (
        .clk          (clk),
        .rst          (rst),
        .cfg_msg_mode (cfg_msg_mode),
        .evt_valid    (evt_valid),
        .evt_vec      (evt_vec),
        .mask_bit0    (mask_q[0]),
        .status_rd    (status_rd),
        .status       (status),
        .irq_level    (irq_level),
        .vec_pulse    (vec_pulse),
        .vec_err      (vec_err)
    );

    nodebell_outreq u_outreq (
        .clk       (clk),
        .rst       (rst),
        .bell_wr   (bell_wr),
        .wdata     (reg_wdata),
        .req_valid (bell_req_valid),
        .req       (req)
    );

    assign bell_req_dest = req.dest;
    assign bell_req_vec  = req.vec;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> (reg_rdata == '0));                             // R12
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_level |-> mask_q[0]);                                      // R3
    AST_POSN_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && dec.hit && dec.slot == SLOT_POSN && !node_ready)
        |=> (reg_rdata == '1));                                        // R4
endmodule

// File: tb/nodebell_regs_bench.sv
`timescale 1ns/1ps
module nodebell_regs_bench;
    localparam int unsigned VEC_COUNT = 4;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [23:0] tag;
    } step_t;

    localparam int NSTEPS = 19;
    localparam step_t STEPS [NSTEPS] = '{
        '{OP_RD,  6'd8,  32'h0,          32'hFFFF_FFFF, "R4"},
        '{OP_RD,  6'd4,  32'h0,          32'h0,         "R2"},
        '{OP_WR,  6'd0,  32'hFFFF_FFFE,  32'h0,         "--"},
        '{OP_RD,  6'd0,  32'h0,          32'hFFFF_FFFE, "R1"},
        '{OP_EV,  6'd0,  32'h1234,       32'h0,         "--"},
        '{OP_IRQ, 6'd0,  32'h0,          32'h0,         "R3"},
        '{OP_RD,  6'd4,  32'h0,          32'h1,         "R6"},
        '{OP_RD,  6'd4,  32'h0,          32'h0,         "R9"},
        '{OP_WR,  6'd0,  32'h1,          32'h0,         "--"},
        '{OP_EV,  6'd0,  32'hFFFF,       32'h0,         "--"},
        '{OP_IRQ, 6'd0,  32'h0,          32'h1,         "R3"},
        '{OP_RD,  6'd0,  32'h0,          32'h1,         "R1"},
        '{OP_WR,  6'd8,  32'h0000_ABCD,  32'h0,         "--"},
        '{OP_RD,  6'd8,  32'h0,          32'hFFFF_FFFF, "R10"},
        '{OP_RD,  6'd12, 32'h0,          32'h0,         "R10"},
        '{OP_RD,  6'd16, 32'h0,          32'h0,         "R10"},
        '{OP_RD,  6'd6,  32'h0,          32'h0,         "R10"},
        '{OP_RD,  6'd4,  32'h0,          32'h1,         "R2"},
        '{OP_IRQ, 6'd0,  32'h0,          32'h0,         "R9"}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cfg_msg_mode = 1'b0;
    logic                 node_ready = 1'b0;
    logic [15:0]          node_id = 16'h0025;
    logic                 reg_wr_en = 1'b0;
    logic                 reg_rd_en = 1'b0;
    logic [5:0]           reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic                 bell_req_valid;
    logic [15:0]          bell_req_dest;
    logic [15:0]          bell_req_vec;
    logic                 evt_valid = 1'b0;
    logic [15:0]          evt_vec = '0;
    logic                 irq_level;
    logic [VEC_COUNT-1:0] vec_pulse;
    logic                 vec_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    nodebell_regs #(.ADDR_W(6), .NODE_W(16), .VEC_COUNT(VEC_COUNT)) u_nodebell_regs (
        .clk(clk), .rst(rst), .cfg_msg_mode(cfg_msg_mode), .node_ready(node_ready),
        .node_id(node_id), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bell_req_valid(bell_req_valid), .bell_req_dest(bell_req_dest),
        .bell_req_vec(bell_req_vec), .evt_valid(evt_valid), .evt_vec(evt_vec),
        .irq_level(irq_level), .vec_pulse(vec_pulse), .vec_err(vec_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk); d = reg_rdata; reg_rd_en = 1'b0;
    endtask

    task automatic do_event(input logic [15:0] v);
        @(negedge clk); evt_valid = 1'b1; evt_vec = v;
        @(negedge clk); evt_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        // R12: reset state of every output
        check("R12", reg_rdata, 32'h0);
        check("R5",  {31'b0, bell_req_valid}, 32'h0);
        check("R3",  {31'b0, irq_level}, 32'h0);
        check("R8",  {28'b0, vec_pulse, vec_err}, 32'h0);

        // Table walk, pin scheme
        for (int i = 0; i < NSTEPS; i++) begin
            case (STEPS[i].op)
                OP_WR:  do_write(STEPS[i].addr, STEPS[i].data);
                OP_EV:  do_event(STEPS[i].data[15:0]);
                OP_RD: begin
                    do_read(STEPS[i].addr, d);
                    check(string'(STEPS[i].tag), d, STEPS[i].exp);
                end
                default: check(string'(STEPS[i].tag), {31'b0, irq_level}, STEPS[i].exp);
            endcase
        end

        // R12: read data returns to zero a cycle after the read
        @(negedge clk);
        check("R12", reg_rdata, 32'h0);

        // R5: doorbell request fields and single-cycle strobe
        do_write(6'd12, 32'h0007_0003);
        check("R5", {31'b0, bell_req_valid}, 32'h1);
        check("R5", {bell_req_dest, bell_req_vec}, 32'h0007_0003);
        @(negedge clk);
        check("R5", {31'b0, bell_req_valid}, 32'h0);

        // R4: identifier once ready
        node_ready = 1'b1;
        do_read(6'd8, d);
        check("R4", d, 32'h0000_0025);

        // R9: event in the same cycle as the status read keeps it set
        do_event(16'h0);
        @(negedge clk); reg_rd_en = 1'b1; reg_addr = 6'd4; evt_valid = 1'b1; evt_vec = 16'h5;
        @(negedge clk); d = reg_rdata; reg_rd_en = 1'b0; evt_valid = 1'b0;
        check("R9", d, 32'h1);
        do_read(6'd4, d);
        check("R9", d, 32'h1);
        do_read(6'd4, d);
        check("R9", d, 32'h0);

        // Message scheme
        cfg_msg_mode = 1'b1;
        do_reset();
        do_write(6'd0, 32'h1);
        do_event(16'd2);
        check("R7", {28'b0, vec_pulse}, 32'h4);
        check("R7", {31'b0, irq_level}, 32'h0);
        @(negedge clk);
        check("R7", {28'b0, vec_pulse}, 32'h0);
        do_read(6'd4, d);
        check("R7", d, 32'h0);
        do_event(16'd4);
        check("R8", {28'b0, vec_pulse}, 32'h0);
        check("R8", {31'b0, vec_err}, 32'h1);
        do_event(16'd1);
        check("R7", {28'b0, vec_pulse}, 32'h2);
        check("R8", {31'b0, vec_err}, 32'h1);

        // R11: scheme input ignored outside reset
        cfg_msg_mode = 1'b0;
        do_event(16'd0);
        check("R11", {28'b0, vec_pulse}, 32'h1);
        do_read(6'd4, d);
        check("R11", d, 32'h0);
        do_reset();
        do_event(16'd0);
        check("R11", {28'b0, vec_pulse}, 32'h0);
        do_read(6'd4, d);
        check("R11", d, 32'h1);
        check("R8", {31'b0, vec_err}, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule